// File: doc/BRIEF.md
# Outbound Notification Interrupt Controller

This block is the register set an I/O processor uses to notify a host. The local core writes two message registers and a doorbell register. The host reads them and acknowledges events by writing ones to clear them. The block combines the pending events with a post-queue-not-empty flag from the queue logic. It masks the result and drives a single level-sensitive interrupt line toward the host.

Each side has its own register port. The core port is a plain write/read port. On the host port, writes to the doorbell and the event status are write-1-to-clear, and a write to the mask register is a plain load. Status bits that follow the doorbell and the queue flag are derived every cycle and are never latched. Only the two message-written flags are stored.

Top module: `ob_notify_ctrl`

## Requirements
- R1: After reset every register reads as zero on both ports and `irq_o` is low.
- R2: A core write to offset 0x18 stores message A and a core write to 0x1C stores message B. Both ports read the stored value back. Host writes to these offsets leave them unchanged.
- R3: A core write to message A sets status bit 0, and a core write to message B sets status bit 1. A host write to the status offset 0x30 with a one in bit 0 or bit 1 clears that bit. If the set and the clear arrive in the same cycle, the bit stays set.
- R4: A core write to the doorbell (0x2C) ORs its data into the doorbell and never clears a bit. A host write to 0x2C clears exactly the bits written as one. If a core set and a host clear of the same bit arrive in the same cycle, the bit stays set.
- R5: Status bit 2 is one exactly while at least one of doorbell bits 30 down to 1 is one. Doorbell bits 0 and 31 do not affect it.
- R6: Status bit 4 equals doorbell bit 28.
- R7: Status bit 3 follows the `post_q_nempty` input in the same cycle.
- R8: The mask register at 0x34 holds five bits, each in the same position as the status bit it masks. It is loaded only by host writes. Core writes to 0x34 and 0x30 have no effect. Changing the mask never changes the status read at 0x30.
- R9: `irq_o` is a register that loads the OR of (status AND NOT mask). A register write therefore shows on `irq_o` one clock edge after the edge that performs the write.
- R10: Reads of any offset other than 0x18, 0x1C, 0x2C, 0x30 and 0x34 return zero, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_en | input | 1 | Core-side write strobe |
| core_addr | input | ADDR_W | Core-side byte offset |
| core_wdata | input | DATA_W | Core-side write data |
| core_rdata | output | DATA_W | Core-side read data (combinational from `core_addr`) |
| host_wr_en | input | 1 | Host-side write strobe |
| host_addr | input | ADDR_W | Host-side byte offset |
| host_wdata | input | DATA_W | Host-side write data (clear pattern or mask value) |
| host_rdata | output | DATA_W | Host-side read data (combinational from `host_addr`) |
| post_q_nempty | input | 1 | Post queue holds at least one entry |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
A register write takes effect at the clock edge that samples it. Register read-back and the derived status bits are therefore valid as soon as that edge has passed. The bench drives every write on a falling edge and reads in the following low phase. `irq_o` is one register further down. The bench samples it once just after the write edge, where it still expects the old level, and again one full cycle later for the new level. A change on `post_q_nempty` appears in status at once and on `irq_o` after the next rising edge. The bench sweeps all 32 doorbell bit positions one at a time, and all 32 mask patterns against a fully set status.

// File: rtl/ob_notify_pkg.sv
package ob_notify_pkg;

  // byte offsets of the register set
  localparam int OFS_MSG_A = 'h18;
  localparam int OFS_MSG_B = 'h1C;
  localparam int OFS_DBELL = 'h2C;
  localparam int OFS_STAT  = 'h30;
  localparam int OFS_MASK  = 'h34;

  // status / mask bit positions
  localparam int ST_MSG_A   = 0;
  localparam int ST_MSG_B   = 1;
  localparam int ST_DBELL   = 2;
  localparam int ST_POSTQ   = 3;
  localparam int ST_HOSTINT = 4;
  localparam int ST_W       = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MSG_A,
    SEL_MSG_B,
    SEL_DBELL,
    SEL_STAT,
    SEL_MASK
  } reg_sel_e;

endpackage

// File: rtl/ob_msg_regs.sv
module ob_msg_regs #(
  parameter int DATA_W = 32,
  parameter int N_MSG  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MSG-1:0]              wr_en,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_MSG-1:0]              ack,
  output logic [N_MSG-1:0][DATA_W-1:0]  msg_q,
  output logic [N_MSG-1:0]              written_q
);

  // a new write outranks a simultaneous acknowledge
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar g = 0; g < N_MSG; g++) begin : g_msg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msg_q[g]     <= '0;
        written_q[g] <= 1'b0;
      end else begin
        if (wr_en[g]) msg_q[g] <= wdata;
        written_q[g] <= flag_next(written_q[g], wr_en[g], ack[g]);
      end
    end
  end

endmodule

// File: rtl/ob_doorbell.sv
module ob_doorbell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [DATA_W-1:0] set_val,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] clr_val,
  output logic [DATA_W-1:0] db_q
);

  // clear first, then OR in new requests so a same-cycle set survives
  function automatic logic [DATA_W-1:0] db_next(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_bits,
    input logic [DATA_W-1:0] clr_bits
  );
    return (cur & ~clr_bits) | set_bits;
  endfunction

  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;

  assign set_bits = set_en ? set_val : '0;
  assign clr_bits = clr_en ? clr_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) db_q <= '0;
    else        db_q <= db_next(db_q, set_bits, clr_bits);
  end

endmodule

// File: rtl/ob_status_irq.sv
module ob_status_irq
  import ob_notify_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DB_LO       = 1,
  parameter int DB_HI       = 30,
  parameter int DB_HOST_BIT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        msg_flags,
  input  logic [DATA_W-1:0] db_q,
  input  logic              post_q_nempty,
  input  logic              mask_wr,
  input  logic [ST_W-1:0]   mask_wdata,
  output logic [ST_W-1:0]   status,
  output logic [ST_W-1:0]   mask_q,
  output logic              irq_q
);

  function automatic logic db_summary(input logic [DATA_W-1:0] db);
    return |db[DB_HI:DB_LO];
  endfunction

  function automatic logic irq_level(input logic [ST_W-1:0] st, input logic [ST_W-1:0] mk);
    return |(st & ~mk);
  endfunction

  always_comb begin
    status             = '0;
    status[ST_MSG_A]   = msg_flags[0];
    status[ST_MSG_B]   = msg_flags[1];
    status[ST_DBELL]   = db_summary(db_q);
    status[ST_POSTQ]   = post_q_nempty;
    status[ST_HOSTINT] = db_q[DB_HOST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      irq_q <= irq_level(status, mask_q);
    end
  end

endmodule

// File: rtl/ob_notify_ctrl.sv
module ob_notify_ctrl
  import ob_notify_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int DB_LO       = 1,
  parameter int DB_HI       = 30,
  parameter int DB_HOST_BIT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_wr_en,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              post_q_nempty,
  output logic              irq_o
);

  localparam int N_MSG = 2;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFS_MSG_A)) return SEL_MSG_A;
    if (a == ADDR_W'(OFS_MSG_B)) return SEL_MSG_B;
    if (a == ADDR_W'(OFS_DBELL)) return SEL_DBELL;
    if (a == ADDR_W'(OFS_STAT))  return SEL_STAT;
    if (a == ADDR_W'(OFS_MASK))  return SEL_MASK;
    return SEL_NONE;
  endfunction

  reg_sel_e core_sel;
  reg_sel_e host_sel;

  // named write events
  logic [N_MSG-1:0]             ev_msg_wr;
  logic [N_MSG-1:0]             ev_msg_ack;
  logic                         ev_db_set;
  logic                         ev_db_clr;
  logic                         ev_mask_wr;

  logic [N_MSG-1:0][DATA_W-1:0] msg_q;
  logic [N_MSG-1:0]             msg_flags;
  logic [DATA_W-1:0]            db_q;
  logic [ST_W-1:0]              status_w;
  logic [ST_W-1:0]              mask_w;

  assign core_sel = decode_ofs(core_addr);
  assign host_sel = decode_ofs(host_addr);

  assign ev_msg_wr[0] = core_wr_en && (core_sel == SEL_MSG_A);
  assign ev_msg_wr[1] = core_wr_en && (core_sel == SEL_MSG_B);
  assign ev_msg_ack   = (host_wr_en && (host_sel == SEL_STAT)) ?
                        {host_wdata[ST_MSG_B], host_wdata[ST_MSG_A]} : '0;
  assign ev_db_set    = core_wr_en && (core_sel == SEL_DBELL);
  assign ev_db_clr    = host_wr_en && (host_sel == SEL_DBELL);
  assign ev_mask_wr   = host_wr_en && (host_sel == SEL_MASK);

  ob_msg_regs #(
    .DATA_W (DATA_W),
    .N_MSG  (N_MSG)
  ) u_msg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ev_msg_wr),
    .wdata     (core_wdata),
    .ack       (ev_msg_ack),
    .msg_q     (msg_q),
    .written_q (msg_flags)
  );

  ob_doorbell #(
    .DATA_W (DATA_W)
  ) u_db (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (ev_db_set),
    .set_val (core_wdata),
    .clr_en  (ev_db_clr),
    .clr_val (host_wdata),
    .db_q    (db_q)
  );

  ob_status_irq #(
    .DATA_W      (DATA_W),
    .DB_LO       (DB_LO),
    .DB_HI       (DB_HI),
    .DB_HOST_BIT (DB_HOST_BIT)
  ) u_st (
    .clk           (clk),
    .rst_n         (rst_n),
    .msg_flags     (msg_flags),
    .db_q          (db_q),
    .post_q_nempty (post_q_nempty),
    .mask_wr       (ev_mask_wr),
    .mask_wdata    (host_wdata[ST_W-1:0]),
    .status        (status_w),
    .mask_q        (mask_w),
    .irq_q         (irq_o)
  );

  function automatic logic [DATA_W-1:0] read_mux(input reg_sel_e sel);
    case (sel)
      SEL_MSG_A: return msg_q[0];
      SEL_MSG_B: return msg_q[1];
      SEL_DBELL: return db_q;
      SEL_STAT:  return DATA_W'(status_w);
      SEL_MASK:  return DATA_W'(mask_w);
      default:   return '0;
    endcase
  endfunction

  assign core_rdata = read_mux(core_sel);
  assign host_rdata = read_mux(host_sel);

endmodule

// File: rtl/ob_notify_ctrl_chk.sv
module ob_notify_ctrl_chk
  import ob_notify_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int DB_LO       = 1,
  parameter int DB_HI       = 30,
  parameter int DB_HOST_BIT = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_wr_en,
  input logic [ADDR_W-1:0] core_addr,
  input logic              host_wr_en,
  input logic [ADDR_W-1:0] host_addr,
  input logic              post_q_nempty,
  input logic [DATA_W-1:0] db_q,
  input logic [ST_W-1:0]   status_w,
  input logic [ST_W-1:0]   mask_w,
  input logic              irq_o
);

  a_r3_msg_a_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_addr == ADDR_W'(OFS_MSG_A)) |=> status_w[ST_MSG_A]);

  a_r3_msg_b_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && core_addr == ADDR_W'(OFS_MSG_B)) |=> status_w[ST_MSG_B]);

  a_r4_db_only_host_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_en && host_addr == ADDR_W'(OFS_DBELL)) |=> ((db_q & $past(db_q)) == $past(db_q)));

  a_r5_db_summary: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[ST_DBELL] == (|db_q[DB_HI:DB_LO]));

  a_r6_hostint_bit: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[ST_HOSTINT] == db_q[DB_HOST_BIT]);

  a_r7_postq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[ST_POSTQ] == post_q_nempty);

  a_r8_mask_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_en && host_addr == ADDR_W'(OFS_MASK)) |=> $stable(mask_w));

  a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|($past(status_w) & ~$past(mask_w)))));

endmodule

bind ob_notify_ctrl ob_notify_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .DB_LO       (DB_LO),
  .DB_HI       (DB_HI),
  .DB_HOST_BIT (DB_HOST_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_wr_en    (core_wr_en),
  .core_addr     (core_addr),
  .host_wr_en    (host_wr_en),
  .host_addr     (host_addr),
  .post_q_nempty (post_q_nempty),
  .db_q          (db_q),
  .status_w      (status_w),
  .mask_w        (mask_w),
  .irq_o         (irq_o)
);

// File: tb/ob_notify_ctrl_tb.sv
`timescale 1ns/1ps
module ob_notify_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_wr_en = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic [DW-1:0] core_rdata;
  logic          host_wr_en = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          post_q_nempty = 1'b0;
  logic          irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ob_notify_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_wr_en(core_wr_en), .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .post_q_nempty(post_q_nempty), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // both strobes are applied in one cycle; returns at the falling edge after the write edge
  task automatic wr(input bit c_en, input logic [AW-1:0] ca, input logic [DW-1:0] cd,
                    input bit h_en, input logic [AW-1:0] ha, input logic [DW-1:0] hd);
    @(negedge clk);
    core_wr_en = c_en; core_addr = ca; core_wdata = cd;
    host_wr_en = h_en; host_addr = ha; host_wdata = hd;
    @(negedge clk);
    core_wr_en = 1'b0; host_wr_en = 1'b0;
  endtask

  task automatic cw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(1'b1, a, d, 1'b0, '0, '0);
  endtask

  task automatic hw(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr(1'b0, '0, '0, 1'b1, a, d);
  endtask

  task automatic hrd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    host_addr = a; #0.1; v = host_rdata;
  endtask

  task automatic crd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    core_addr = a; #0.1; v = core_rdata;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] exp_st;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    begin
      int ofs [5] = '{'h18, 'h1C, 'h2C, 'h30, 'h34};
      foreach (ofs[k]) begin
        hrd(AW'(ofs[k]), v); check("R1 host read after reset", v, 0);
        crd(AW'(ofs[k]), v); check("R1 core read after reset", v, 0);
      end
    end
    check("R1 irq after reset", DW'(irq_o), 0);

    // R10: undefined offsets
    cw(8'h20, 32'hFFFF_FFFF);
    hw(8'h24, 32'hFFFF_FFFF);
    cw(8'h00, 32'h1234_5678);
    for (int a = 0; a < 256; a += 4) begin
      hrd(AW'(a), v);
      if (a != 'h18 && a != 'h1C && a != 'h2C && a != 'h30 && a != 'h34)
        check("R10 undefined offset reads zero", v, 0);
      else
        check("R10 defined offsets untouched", v, 0);
    end
    cyc();
    check("R10 irq stays low", DW'(irq_o), 0);

    // R2 / R3: message A
    cw(8'h18, 32'hA5A5_0001);
    hrd(8'h18, v); check("R2 msg A host readback", v, 32'hA5A5_0001);
    crd(8'h18, v); check("R2 msg A core readback", v, 32'hA5A5_0001);
    hrd(8'h30, v); check("R3 msg A sets status bit0", v, 32'h1);
    check("R9 irq not yet raised at write edge", DW'(irq_o), 0);
    cyc();
    check("R9 irq raised one edge later", DW'(irq_o), 1);
    hw(8'h18, 32'h0BAD_0BAD);
    hrd(8'h18, v); check("R2 host write to msg A ignored", v, 32'hA5A5_0001);
    hw(8'h30, 32'h1);
    hrd(8'h30, v); check("R3 status bit0 cleared by host", v, 0);
    check("R9 irq still high at clear edge", DW'(irq_o), 1);
    cyc();
    check("R9 irq low one edge after clear", DW'(irq_o), 0);

    // R2 / R3: message B and set-beats-clear
    cw(8'h1C, 32'h0000_BEEF);
    hrd(8'h1C, v); check("R2 msg B readback", v, 32'h0000_BEEF);
    hrd(8'h30, v); check("R3 msg B sets status bit1", v, 32'h2);
    hw(8'h30, 32'h1);
    hrd(8'h30, v); check("R3 clearing bit0 leaves bit1", v, 32'h2);
    wr(1'b1, 8'h1C, 32'h0000_CAFE, 1'b1, 8'h30, 32'h2);
    hrd(8'h30, v); check("R3 same-cycle write beats clear", v, 32'h2);
    hw(8'h30, 32'hFFFF_FFFF);
    hrd(8'h30, v); check("R3 status all cleared", v, 0);

    // R4 / R5 / R6: single-bit doorbell sweep
    for (int i = 0; i < DW; i++) begin
      logic [DW-1:0] bitv;
      bitv = DW'(1) << i;
      cw(8'h2C, bitv);
      hrd(8'h2C, v); check("R4 doorbell bit set by core", v, bitv);
      exp_st = '0;
      exp_st[2] = (i >= 1 && i <= 30);
      exp_st[4] = (i == 28);
      hrd(8'h30, v); check("R5 R6 status from doorbell bit", v, exp_st);
      cyc();
      check("R9 irq from doorbell bit", DW'(irq_o), DW'(exp_st != 0));
      cw(8'h2C, 32'h0);
      hrd(8'h2C, v); check("R4 core cannot clear doorbell", v, bitv);
      hw(8'h2C, ~bitv);
      hrd(8'h2C, v); check("R4 host clears only written ones", v, bitv);
      hw(8'h2C, bitv);
      hrd(8'h2C, v); check("R4 host clears written bit", v, 0);
      hrd(8'h30, v); check("R5 summary drops when bits clear", v, 0);
    end
    cw(8'h2C, 32'hF000_000F);
    hw(8'h2C, 32'h0000_0003);
    hrd(8'h2C, v); check("R4 partial host clear", v, 32'hF000_000C);
    wr(1'b1, 8'h2C, 32'h0000_0004, 1'b1, 8'h2C, 32'h0000_0004);
    hrd(8'h2C, v); check("R4 same-cycle set beats clear", v, 32'hF000_000C);
    hw(8'h2C, 32'hFFFF_FFFF);
    cw(8'h2C, 32'h8000_0001);
    hrd(8'h30, v); check("R5 bits 0 and 31 excluded", v, 0);
    hw(8'h2C, 32'hFFFF_FFFF);
    cyc();

    // R7: post queue flag
    post_q_nempty = 1'b1; #0.1;
    hrd(8'h30, v); check("R7 status bit3 follows input", v, 32'h8);
    check("R7 irq waits for edge", DW'(irq_o), 0);
    cyc();
    check("R7 irq after edge", DW'(irq_o), 1);
    post_q_nempty = 1'b0; #0.1;
    hrd(8'h30, v); check("R7 status bit3 drops", v, 0);
    cyc();

    // R8 / R9: mask sweep against a fully set status
    cw(8'h18, 32'h1);
    cw(8'h1C, 32'h2);
    cw(8'h2C, 32'h1000_0000);
    post_q_nempty = 1'b1;
    for (int m = 0; m < 32; m++) begin
      hw(8'h34, DW'(m));
      hrd(8'h34, v); check("R8 mask readback", v, DW'(m));
      hrd(8'h30, v); check("R8 mask leaves status alone", v, 32'h1F);
      cyc();
      check("R9 irq under mask", DW'(irq_o), DW'((~m & 'h1F) != 0));
    end
    cw(8'h34, 32'h0);
    hrd(8'h34, v); check("R8 core write to mask ignored", v, 32'h1F);
    cw(8'h30, 32'h0);
    hrd(8'h30, v); check("R8 core write to status ignored", v, 32'h1F);
    hw(8'h34, 32'h0);
    cyc();
    check("R9 irq with mask cleared", DW'(irq_o), 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule